// File: doc/BRIEF.md
# SDRAM Write-Burst Termination Sequencer

This block schedules commands for one SDRAM data path on the controller side. It issues four-beat WRITE bursts and lets a later request cut an active burst short. The later request can be another WRITE, a READ, a PRECHARGE of one bank or of all banks, or an ACTIVATE. Every WRITE request carries a count of wanted beats. The block finds the earliest legal cycle for the next command from that count, the CAS latency and the write-recovery and precharge times. Until that cycle arrives it holds the request with ready low. It drives the DQ output enable and the per-byte data mask, so the bus never sees two drivers and no unwanted beat reaches the memory array.

Requests arrive on a valid/ready port. Each carries a kind, a bank, a row, a column, an all-banks flag, a beat count and four packed data words. The command, address and data pins are registered, so a command accepted on one clock edge shows on the pins during the next cycle. The write-recovery and precharge times are parameters in picoseconds. They are turned into whole clock cycles by rounding up when the design is elaborated.

Top module: `wburst_sched`

## Requirements
- R1: After reset the pins carry NOP, the DQ output enable and all mask lanes are low, and a WRITE request is accepted at once (ready high).
- R2: An accepted WRITE appears on the pins in the following cycle, with the bank on the bank pins, the column in the low address bits and address bit 10 low. Beat k (word k of the request data, word 0 in the least significant bits) is driven with the output enable high k cycles later, for every k below the wanted count.
- R3: Every cycle that follows a clock edge on which no request was accepted carries NOP. A request that may not issue yet is held with ready low, and it issues nothing until it is accepted.
- R4: After a WRITE with n wanted beats, a WRITE or READ is accepted no earlier than n cycles after the WRITE was accepted. When one is already waiting, it is accepted exactly then. A new WRITE's beats take over the DQ pins from the cycle it issues, replacing the old burst's remaining beats.
- R5: The output enable is low in the cycle a READ issues and stays low until the next WRITE, so no unwanted write beats follow the READ. No command of any kind is accepted until CAS latency plus 4 cycles after the READ was accepted.
- R6: After a WRITE with n wanted beats, a PRECHARGE is accepted no earlier than n-1+m cycles after the WRITE, where m is the write-recovery time divided by the clock period, rounded up (4 by default). Address bit 10 carries the all-banks flag.
- R7: All mask lanes are high in every cycle from the one after the last wanted beat up to the next command, and also in a PRECHARGE cycle reached that way. The mask is low during wanted beats and in WRITE, READ and ACTIVATE cycles.
- R8: An ACTIVATE is accepted no earlier than the precharge time divided by the clock period, rounded up (5 by default), after a PRECHARGE. It carries the row on the address pins.
- R9: The pins {chip select, row strobe, column strobe, write enable} (all active low) encode NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010.
- R10: A beat count of 0, or one above 4, is taken as a full 4-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge if valid |
| reqKind | input | 2 | 0 WRITE, 1 READ, 2 PRECHARGE, 3 ACTIVATE |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row for ACTIVATE |
| reqCol | input | COL_W | Column for WRITE and READ |
| reqAllBanks | input | 1 | PRECHARGE applies to all banks |
| reqBeats | input | clog2(BURST+1) | Wanted write beats |
| reqData | input | BURST*DQ_W | Write words, word 0 lowest |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ROW_W | Address pins |
| sdDqOut | output | DQ_W | Write data toward DQ |
| sdDqOe | output | 1 | DQ output enable |
| sdDqm | output | DQ_W/8 | Per-byte data mask |

## Verification
Each WRITE is cut short by a different kind of follower, with a different wanted count each time. One wanted beat followed by a WRITE shows the one-cycle interval and the handover of the data pins. Two beats followed by a READ show the bus release and the wait after a READ. Three and four beats followed by an all-bank and a single-bank PRECHARGE separate the n-1+m spacing from the plain n spacing and show how long the mask is held. A count of 0 followed by a READ shows that a zero count is taken as a full burst, and an ACTIVATE after a PRECHARGE shows the precharge-time wait.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  typedef enum logic [1:0] {
    REQ_WRITE = 2'd0,
    REQ_READ  = 2'd1,
    REQ_PRE   = 2'd2,
    REQ_ACT   = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic issueWr;
    logic issueRd;
    logic issuePre;
    logic issueAct;
  } strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_ACT = 4'b0011;
  localparam logic [3:0] PIN_RD  = 4'b0101;
  localparam logic [3:0] PIN_WR  = 4'b0100;
  localparam logic [3:0] PIN_PRE = 4'b0010;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/wbs_ctrl.sv
`timescale 1ns/1ps
module wbs_ctrl
  import wbs_pkg::*;
#(
  parameter int BURST   = 4,
  parameter int CAS_LAT = 2,
  parameter int WR_CYC  = 4,
  parameter int RP_CYC  = 5,
  parameter int BEAT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [BEAT_W-1:0] reqBeats,
  output logic              reqReady,
  output strobe_t           strobe,
  output logic [BEAT_W-1:0] beatsEff
);
  localparam int RD_HOLD  = CAS_LAT + BURST - 1;
  localparam int PRE_HOLD = BURST + WR_CYC - 2;
  localparam int ACT_HOLD = RP_CYC - 1;
  localparam int HOLD_A   = (RD_HOLD > PRE_HOLD) ? RD_HOLD : PRE_HOLD;
  localparam int HOLD_MAX = (HOLD_A > ACT_HOLD) ? HOLD_A : ACT_HOLD;
  localparam int CNT_W    = $clog2(HOLD_MAX + 2);

  logic [CNT_W-1:0] rwCnt, preCnt, actCnt;
  logic [CNT_W-1:0] rwDec, preDec, actDec;
  logic             fire;
  reqKind_e         kind;

  assign kind = reqKind_e'(reqKind);

  always_comb begin
    if (reqBeats == '0 || int'(reqBeats) > BURST) beatsEff = BEAT_W'(BURST);
    else                                           beatsEff = reqBeats;
  end

  assign rwDec  = (rwCnt  != '0) ? rwCnt  - 1'b1 : '0;
  assign preDec = (preCnt != '0) ? preCnt - 1'b1 : '0;
  assign actDec = (actCnt != '0) ? actCnt - 1'b1 : '0;

  always_comb begin
    unique case (kind)
      REQ_WRITE, REQ_READ: reqReady = (rwCnt == '0);
      REQ_PRE:             reqReady = (preCnt == '0);
      default:             reqReady = (actCnt == '0) && (rwCnt == '0);
    endcase
  end

  assign fire            = reqValid && reqReady;
  assign strobe.issueWr  = fire && (kind == REQ_WRITE);
  assign strobe.issueRd  = fire && (kind == REQ_READ);
  assign strobe.issuePre = fire && (kind == REQ_PRE);
  assign strobe.issueAct = fire && (kind == REQ_ACT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rwCnt  <= '0;
      preCnt <= '0;
      actCnt <= '0;
    end else begin
      rwCnt  <= rwDec;
      preCnt <= preDec;
      actCnt <= actDec;
      if (strobe.issueWr) begin
        rwCnt  <= CNT_W'(int'(beatsEff) - 1);
        preCnt <= CNT_W'(int'(beatsEff) + WR_CYC - 2);
      end
      if (strobe.issueRd) begin
        rwCnt <= CNT_W'(RD_HOLD);
        if (int'(preDec) < RD_HOLD) preCnt <= CNT_W'(RD_HOLD);
      end
      if (strobe.issuePre) actCnt <= CNT_W'(ACT_HOLD);
    end
  end

  // Spacing observer: cycles since the latest accepted WRITE
  localparam int SINCE_MAX = BURST + WR_CYC;
  localparam int SINCE_W   = $clog2(SINCE_MAX + 1);
  logic [SINCE_W-1:0] sinceWr;
  logic               wrSeen;
  logic [BEAT_W-1:0]  lastBeats;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWr   <= '0;
      wrSeen    <= 1'b0;
      lastBeats <= '0;
    end else if (strobe.issueWr) begin
      sinceWr   <= SINCE_W'(1);
      wrSeen    <= 1'b1;
      lastBeats <= beatsEff;
    end else if (int'(sinceWr) < SINCE_MAX) begin
      sinceWr <= sinceWr + 1'b1;
    end
  end

  assert_rw_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.issueWr || strobe.issueRd) && wrSeen) |-> (int'(sinceWr) >= int'(lastBeats)));

  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issuePre && wrSeen) |-> (int'(sinceWr) >= int'(lastBeats) - 1 + WR_CYC));

  assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/wbs_datapath.sv
`timescale 1ns/1ps
module wbs_datapath
  import wbs_pkg::*;
#(
  parameter int DQ_W   = 32,
  parameter int BYTES  = 4,
  parameter int BURST  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  parameter int BEAT_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic [ROW_W-1:0]      reqRow,
  input  logic [COL_W-1:0]      reqCol,
  input  logic                  reqAllBanks,
  input  logic [BURST*DQ_W-1:0] reqData,
  input  logic [BEAT_W-1:0]     beatsEff,
  output logic [3:0]            pinCmd,
  output logic [BANK_W-1:0]     sdBa,
  output logic [ROW_W-1:0]      sdAddr,
  output logic [DQ_W-1:0]       sdDqOut,
  output logic                  sdDqOe,
  output logic [BYTES-1:0]      sdDqm
);
  localparam int PEND_W = (BURST - 1) * DQ_W;

  logic [3:0]        cmdNext;
  logic [ROW_W-1:0]  addrNext;
  logic [BANK_W-1:0] baNext;
  logic [PEND_W-1:0] pending;
  logic [BEAT_W-1:0] left;
  logic              maskBit;
  logic              tailArmed;

  always_comb begin
    cmdNext  = PIN_NOP;
    addrNext = '0;
    baNext   = sdBa;
    if (strobe.issueWr) begin
      cmdNext               = PIN_WR;
      addrNext[COL_W-1:0]   = reqCol;
      baNext                = reqBank;
    end else if (strobe.issueRd) begin
      cmdNext               = PIN_RD;
      addrNext[COL_W-1:0]   = reqCol;
      baNext                = reqBank;
    end else if (strobe.issuePre) begin
      cmdNext               = PIN_PRE;
      addrNext[AP_BIT]      = reqAllBanks;
      baNext                = reqBank;
    end else if (strobe.issueAct) begin
      cmdNext               = PIN_ACT;
      addrNext              = reqRow;
      baNext                = reqBank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinCmd    <= PIN_NOP;
      sdBa      <= '0;
      sdAddr    <= '0;
      sdDqOut   <= '0;
      sdDqOe    <= 1'b0;
      maskBit   <= 1'b0;
      left      <= '0;
      tailArmed <= 1'b0;
      pending   <= '0;
    end else begin
      pinCmd <= cmdNext;
      sdBa   <= baNext;
      sdAddr <= addrNext;
      if (strobe.issueWr) begin
        sdDqOut   <= reqData[DQ_W-1:0];
        pending   <= reqData[BURST*DQ_W-1:DQ_W];
        left      <= beatsEff - 1'b1;
        sdDqOe    <= 1'b1;
        maskBit   <= 1'b0;
        tailArmed <= 1'b1;
      end else if (strobe.issueRd || strobe.issueAct) begin
        sdDqOut   <= '0;
        left      <= '0;
        sdDqOe    <= 1'b0;
        maskBit   <= 1'b0;
        tailArmed <= 1'b0;
      end else if (strobe.issuePre) begin
        sdDqOut   <= '0;
        left      <= '0;
        sdDqOe    <= 1'b0;
        maskBit   <= tailArmed;
        tailArmed <= 1'b0;
      end else if (left != '0) begin
        sdDqOut <= pending[DQ_W-1:0];
        pending <= pending >> DQ_W;
        left    <= left - 1'b1;
        sdDqOe  <= 1'b1;
        maskBit <= 1'b0;
      end else begin
        sdDqOut <= '0;
        sdDqOe  <= 1'b0;
        maskBit <= tailArmed;
      end
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : gLane
    assign sdDqm[b] = maskBit;
  end

  assert_rd_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == PIN_RD) |-> !sdDqOe);

  assert_wr_first_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == PIN_WR) |-> (sdDqOe && !maskBit));

  assert_pre_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((pinCmd == PIN_PRE) && $past(maskBit)) |-> maskBit);

  assert_idle_nop_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|strobe) |-> (pinCmd == PIN_NOP));
endmodule

// File: rtl/wburst_sched.sv
`timescale 1ns/1ps
module wburst_sched
  import wbs_pkg::*;
#(
  parameter int DQ_W    = 32,
  parameter int BURST   = 4,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 2,
  parameter int T_CK_PS = 4000,
  parameter int T_WR_PS = 15000,
  parameter int T_RP_PS = 18000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [1:0]                   reqKind,
  input  logic [BANK_W-1:0]            reqBank,
  input  logic [ROW_W-1:0]             reqRow,
  input  logic [COL_W-1:0]             reqCol,
  input  logic                         reqAllBanks,
  input  logic [$clog2(BURST+1)-1:0]   reqBeats,
  input  logic [BURST*DQ_W-1:0]        reqData,
  output logic                         sdCsN,
  output logic                         sdRasN,
  output logic                         sdCasN,
  output logic                         sdWeN,
  output logic [BANK_W-1:0]            sdBa,
  output logic [ROW_W-1:0]             sdAddr,
  output logic [DQ_W-1:0]              sdDqOut,
  output logic                         sdDqOe,
  output logic [DQ_W/8-1:0]            sdDqm
);
  localparam int BYTES  = DQ_W / 8;
  localparam int BEAT_W = $clog2(BURST + 1);
  localparam int WR_CYC = ceilDiv(T_WR_PS, T_CK_PS);
  localparam int RP_CYC = ceilDiv(T_RP_PS, T_CK_PS);

  strobe_t           strobe;
  logic [BEAT_W-1:0] beatsEff;
  logic [3:0]        pinCmd;

  wbs_ctrl #(
    .BURST(BURST), .CAS_LAT(CAS_LAT), .WR_CYC(WR_CYC), .RP_CYC(RP_CYC), .BEAT_W(BEAT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqBeats(reqBeats),
    .reqReady(reqReady), .strobe(strobe), .beatsEff(beatsEff)
  );

  wbs_datapath #(
    .DQ_W(DQ_W), .BYTES(BYTES), .BURST(BURST), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .AP_BIT(AP_BIT), .BEAT_W(BEAT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqAllBanks(reqAllBanks), .reqData(reqData), .beatsEff(beatsEff),
    .pinCmd(pinCmd), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqm(sdDqm)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pinCmd;
endmodule

// File: tb/wburst_sched_tb.sv
`timescale 1ns/1ps
module wburst_sched_tb_top;
  localparam int CL    = 2;
  localparam int BURST = 4;
  localparam int TCK   = 4000;
  localparam int TWR   = 15000;
  localparam int TRP   = 18000;
  localparam int MWR   = (TWR + TCK - 1) / TCK;
  localparam int MRP   = (TRP + TCK - 1) / TCK;
  localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011, E_RD = 4'b0101,
                         E_WR = 4'b0100, E_PRE = 4'b0010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN, reqValid, reqReady, reqAllBanks;
  logic [1:0]   reqKind, reqBank;
  logic [11:0]  reqRow;
  logic [7:0]   reqCol;
  logic [2:0]   reqBeats;
  logic [127:0] reqData;
  logic         sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [1:0]   sdBa;
  logic [11:0]  sdAddr;
  logic [31:0]  sdDqOut;
  logic [3:0]   sdDqm;

  wburst_sched #(
    .CAS_LAT(CL), .BURST(BURST), .T_CK_PS(TCK), .T_WR_PS(TWR), .T_RP_PS(TRP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqAllBanks(reqAllBanks),
    .reqBeats(reqBeats), .reqData(reqData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqOut(sdDqOut),
    .sdDqOe(sdDqOe), .sdDqm(sdDqm)
  );

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  cmdLog [0:4095];
  logic [11:0] addrLog[0:4095];
  logic [1:0]  baLog  [0:4095];
  logic [31:0] dqLog  [0:4095];
  logic        oeLog  [0:4095];
  logic [3:0]  dqmLog [0:4095];

  always @(negedge clk) begin
    cmdLog [cyc % 4096] = {sdCsN, sdRasN, sdCasN, sdWeN};
    addrLog[cyc % 4096] = sdAddr;
    baLog  [cyc % 4096] = sdBa;
    dqLog  [cyc % 4096] = sdDqOut;
    oeLog  [cyc % 4096] = sdDqOe;
    dqmLog [cyc % 4096] = sdDqm;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] words(input logic [31:0] base);
    return {base + 32'd3, base + 32'd2, base + 32'd1, base};
  endfunction

  // called at a negedge; returns at a negedge with the request withdrawn
  task automatic send(input logic [1:0] k, input logic [1:0] b, input logic [11:0] row,
                      input logic [7:0] col, input logic all, input logic [2:0] n,
                      input logic [127:0] d, output int acc);
    reqKind = k; reqBank = b; reqRow = row; reqCol = col; reqAllBanks = all;
    reqBeats = n; reqData = d; reqValid = 1'b1;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqBank = '0; reqRow = '0;
    reqCol = '0; reqAllBanks = 1'b0; reqBeats = 3'd1; reqData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "reset cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, E_NOP);
    check("R1", "reset oe", sdDqOe, 1'b0);
    check("R1", "reset dqm", sdDqm, 4'h0);
    check("R1", "reset ready", reqReady, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_wr_wr();
    int aA, aB, pA, pB;
    send(2'd0, 2'd1, 12'h0, 8'h10, 1'b0, 3'd1, words(32'hA000_0000), aA);
    send(2'd0, 2'd1, 12'h0, 8'h20, 1'b0, 3'd4, words(32'hB000_0000), aB);
    repeat (8) @(negedge clk);
    pA = aA + 1; pB = aB + 1;
    check("R4", "wr-wr spacing", aB - aA, 1);
    check("R9", "write code", cmdLog[pA % 4096], E_WR);
    check("R2", "write col", addrLog[pA % 4096], 12'h010);
    check("R2", "write bank", baLog[pA % 4096], 2'd1);
    check("R2", "beat0 A", dqLog[pA % 4096], 32'hA000_0000);
    check("R2", "beat0 A oe", oeLog[pA % 4096], 1'b1);
    for (int k = 0; k < 4; k++) begin
      check("R4", "beat B", dqLog[(pB + k) % 4096], 32'hB000_0000 + 32'(k));
      check("R7", "beat B dqm", dqmLog[(pB + k) % 4096], 4'h0);
    end
    check("R7", "tail dqm", dqmLog[(pB + 4) % 4096], 4'hF);
    check("R2", "tail oe", oeLog[(pB + 4) % 4096], 1'b0);
  endtask

  task automatic t_wr_rd();
    int aW, aR, aW2, pW, pR;
    send(2'd0, 2'd0, 12'h0, 8'h30, 1'b0, 3'd2, words(32'hC000_0000), aW);
    send(2'd1, 2'd0, 12'h0, 8'h33, 1'b0, 3'd1, '0, aR);
    send(2'd0, 2'd0, 12'h0, 8'h40, 1'b0, 3'd4, words(32'hD000_0000), aW2);
    repeat (8) @(negedge clk);
    pW = aW + 1; pR = aR + 1;
    check("R4", "wr-rd spacing", aR - aW, 2);
    check("R2", "beat1 C", dqLog[(pW + 1) % 4096], 32'hC000_0001);
    check("R9", "read code", cmdLog[pR % 4096], E_RD);
    check("R5", "oe at read", oeLog[pR % 4096], 1'b0);
    check("R5", "oe after read", oeLog[(pR + 1) % 4096], 1'b0);
    check("R7", "dqm at read", dqmLog[pR % 4096], 4'h0);
    check("R3", "nop after read", cmdLog[(pR + 1) % 4096], E_NOP);
    check("R5", "rd-next spacing", aW2 - aR, CL + BURST);
  endtask

  task automatic t_wr_pre_act();
    int aW, aP, aA, pW, pP;
    send(2'd0, 2'd2, 12'h0, 8'h50, 1'b0, 3'd3, words(32'hE000_0000), aW);
    send(2'd2, 2'd2, 12'h0, 8'h00, 1'b1, 3'd1, '0, aP);
    send(2'd3, 2'd2, 12'h5A5, 8'h00, 1'b0, 3'd1, '0, aA);
    repeat (4) @(negedge clk);
    pW = aW + 1; pP = aP + 1;
    check("R6", "wr-pre spacing n=3", aP - aW, 3 - 1 + MWR);
    check("R9", "pre code", cmdLog[pP % 4096], E_PRE);
    check("R6", "all-bank bit", addrLog[pP % 4096][10], 1'b1);
    check("R7", "dqm last wanted beat", dqmLog[(pW + 2) % 4096], 4'h0);
    check("R7", "dqm after last beat", dqmLog[(pW + 3) % 4096], 4'hF);
    check("R7", "dqm on pre", dqmLog[pP % 4096], 4'hF);
    check("R7", "dqm after pre", dqmLog[(pP + 1) % 4096], 4'h0);
    for (int c = pW + 3; c < pP; c++) check("R3", "nop while held", cmdLog[c % 4096], E_NOP);
    check("R8", "pre-act spacing", aA - aP, MRP);
    check("R9", "act code", cmdLog[(aA + 1) % 4096], E_ACT);
    check("R8", "act row", addrLog[(aA + 1) % 4096], 12'h5A5);
  endtask

  task automatic t_pre_single();
    int aW, aP, pW, pP;
    send(2'd0, 2'd3, 12'h0, 8'h60, 1'b0, 3'd4, words(32'hF000_0000), aW);
    send(2'd2, 2'd3, 12'h0, 8'h00, 1'b0, 3'd1, '0, aP);
    repeat (4) @(negedge clk);
    pW = aW + 1; pP = aP + 1;
    check("R6", "wr-pre spacing n=4", aP - aW, 4 - 1 + MWR);
    check("R6", "single-bank bit", addrLog[pP % 4096][10], 1'b0);
    check("R6", "pre bank", baLog[pP % 4096], 2'd3);
    check("R2", "beat3 F", dqLog[(pW + 3) % 4096], 32'hF000_0003);
    check("R7", "dqm on pre n=4", dqmLog[pP % 4096], 4'hF);
  endtask

  task automatic t_zero_count();
    int aW, aR, pW;
    send(2'd0, 2'd0, 12'h0, 8'h70, 1'b0, 3'd0, words(32'h1200_0000), aW);
    send(2'd1, 2'd0, 12'h0, 8'h71, 1'b0, 3'd1, '0, aR);
    repeat (8) @(negedge clk);
    pW = aW + 1;
    check("R10", "zero count spacing", aR - aW, BURST);
    for (int k = 0; k < 4; k++) begin
      check("R10", "zero count beat", dqLog[(pW + k) % 4096], 32'h1200_0000 + 32'(k));
      check("R10", "zero count oe", oeLog[(pW + k) % 4096], 1'b1);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_wr_wr();
    t_wr_rd();
    t_wr_pre_act();
    t_pre_single();
    t_zero_count();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule